// File: doc/BRIEF.md
# Private L1 MESI Line Controller

This block holds the coherence state of a small direct-mapped private data cache. Each line keeps a tag, one data word and one of four stable states: Modified (writable and dirty), Exclusive (writable and clean), Shared (read-only, other copies may exist) and Invalid. Core loads and stores arrive on a valid/ready channel. Misses become GETS or GETX requests to the shared second level, and dirty victims are written back with PUTX. Incoming invalidate and forward-for-read snoops are answered from the line array.

The controller keeps one miss in flight at a time. While a miss is open, `core_req_ready` stays low. A request is taken on a cycle where `core_req_valid` and `core_req_ready` are both high. The L2 request channel uses the same valid/ready rule: once valid is raised, type, address and data stay stable until ready is seen. The core response and snoop response are single-cycle pulses that must be accepted when they appear.

The second level never snoops a line whose write-back is still pending. Grants arrive only while a GETS or GETX is open.

A read miss may be granted in the Exclusive state. A later store to that line then completes locally. Clean lines are dropped from the cache without any message.

Top module: `l1_mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid and the controller is idle: `core_req_ready` is 1, and `l2_req_valid`, `core_rsp_valid` and `snp_rsp_valid` are 0. The first load to any address therefore issues a GETS.
- R2: A load miss issues `l2_req_type` 0 (GETS) for the requested address.
  - On a grant with `l2_gnt_excl` 1 the line is installed Exclusive; otherwise it is installed Shared.
  - `core_rsp_data` returns the grant data one cycle after the grant.
- R3: A store to an Exclusive line moves it to Modified and writes the data. No L2 request is made, and the response follows one cycle after acceptance.
- R4: Replacing a Shared or Exclusive line on a miss sends no PUTX; only the GETS or GETX of the new line appears.
- R5: Replacing a Modified line sends `l2_req_type` 2 (PUTX) with the victim's address and data. The request for the new line follows the PUTX.
- R6: A store to a Shared or absent line issues `l2_req_type` 1 (GETX). On the grant the line is installed Modified with the store data, and later loads return that data.
- R7: An invalidate (`snp_type` 0) on a present line makes it Invalid.
  - If the line was Modified, the snoop response carries its data with `snp_rsp_has_data` and `snp_rsp_dirty` set.
- R8: A forward-for-read (`snp_type` 1) on a Modified or Exclusive line returns its data, with `snp_rsp_dirty` set only for Modified. The line drops to Shared, so a later store issues GETX.
- R9: From acceptance of a miss until its grant, `core_req_ready` is 0, so only one miss is outstanding.
- R10: Snoops take priority: `core_req_ready` is 0 in any cycle with `snp_valid` high. The snoop response is valid exactly one cycle after each snoop cycle.
- R11: A snoop whose tag does not match, or that hits an Invalid line, is acknowledged with `snp_rsp_has_data` 0 and leaves the line unchanged.
- R12: While `l2_req_valid` is 1 and `l2_req_ready` is 0, the request type and address hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Controller accepts a core request this cycle |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | IDX_W+TAG_W | Word address, index in the low bits |
| core_req_wdata | input | DATA_W | Store data |
| core_rsp_valid | output | 1 | One-cycle completion pulse |
| core_rsp_data | output | DATA_W | Load data, or the stored data for a store |
| l2_req_valid | output | 1 | Request to L2 present |
| l2_req_ready | input | 1 | L2 takes the request |
| l2_req_type | output | 2 | 0 GETS, 1 GETX, 2 PUTX |
| l2_req_addr | output | IDX_W+TAG_W | Request address |
| l2_req_data | output | DATA_W | Write-back data (PUTX) |
| l2_gnt_valid | input | 1 | Grant for the open miss |
| l2_gnt_excl | input | 1 | Grant is exclusive |
| l2_gnt_data | input | DATA_W | Granted line data |
| snp_valid | input | 1 | Snoop present |
| snp_type | input | 1 | 0 invalidate, 1 forward-for-read |
| snp_addr | input | IDX_W+TAG_W | Snoop address |
| snp_rsp_valid | output | 1 | Snoop acknowledgement pulse |
| snp_rsp_has_data | output | 1 | Response carries line data |
| snp_rsp_dirty | output | 1 | Supplied data was Modified |
| snp_rsp_data | output | DATA_W | Supplied line data |

## Verification
Load misses are run with both exclusive and shared grants. A following store then shows whether the line was installed Exclusive (no new request) or Shared (a GETX).

Conflicting addresses on one index replace lines in each of the Modified, Exclusive and Shared states. These cases separate the PUTX write-back from silent drops.

Invalidate and forward snoops are applied to Modified, Exclusive and Shared lines, and to a non-matching tag. The dirty flag and data in each response, and the request type of the next access, show what state each snoop left behind.

The L2 model holds ready low for one cycle on every request. That exposes request stability, and confirms that the core is stalled for the whole miss.

// File: rtl/l1_mesi_pkg.sv
package l1_mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  localparam logic [1:0] REQ_GETS = 2'd0;
  localparam logic [1:0] REQ_GETX = 2'd1;
  localparam logic [1:0] REQ_PUTX = 2'd2;

  localparam logic SNP_INV = 1'b0;
  localparam logic SNP_FWD = 1'b1;
endpackage

// File: rtl/l1_line_array.sv
module l1_line_array
  import l1_mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup port for the miss engine
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output line_st_t          rd_st,
  output logic [DATA_W-1:0] rd_data,
  // lookup port for snoops
  input  logic [IDX_W-1:0]  sn_idx,
  output logic [TAG_W-1:0]  sn_tag,
  output line_st_t          sn_st,
  output logic [DATA_W-1:0] sn_data,
  // engine write port (wins on the same index)
  input  logic              fw_en,
  input  logic [IDX_W-1:0]  fw_idx,
  input  logic [TAG_W-1:0]  fw_tag,
  input  line_st_t          fw_st,
  input  logic              fw_data_en,
  input  logic [DATA_W-1:0] fw_data,
  // snoop state write port
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_t          sw_st
);
  localparam int NLINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [NLINES];
  line_st_t          st_q   [NLINES];
  logic [DATA_W-1:0] data_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic hit_f, hit_s;
    assign hit_f = fw_en && (fw_idx == IDX_W'(g));
    assign hit_s = sw_en && (sw_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (hit_f) begin
        st_q[g]  <= fw_st;
        tag_q[g] <= fw_tag;
        if (fw_data_en) data_q[g] <= fw_data;
      end else if (hit_s) begin
        st_q[g] <= sw_st;
      end
    end
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_st   = st_q[rd_idx];
  assign rd_data = data_q[rd_idx];
  assign sn_tag  = tag_q[sn_idx];
  assign sn_st   = st_q[sn_idx];
  assign sn_data = data_q[sn_idx];
endmodule

// File: rtl/l1_snoop_unit.sv
module l1_snoop_unit
  import l1_mesi_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic              snp_type,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_t          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd_en,
  output line_st_t          upd_st,
  output logic              rsp_valid,
  output logic              rsp_has_data,
  output logic              rsp_dirty,
  output logic [DATA_W-1:0] rsp_data
);
  logic present, owner, supply;

  assign present = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
  assign owner   = (line_st == ST_M) || (line_st == ST_E);
  // invalidate returns data only for a dirty line; forward returns it for any owner
  assign supply  = present && ((snp_type == SNP_INV) ? (line_st == ST_M) : owner);

  always_comb begin
    upd_en = present && ((snp_type == SNP_INV) || owner);
    upd_st = (snp_type == SNP_INV) ? ST_I : ST_S;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_has_data <= 1'b0;
      rsp_dirty    <= 1'b0;
      rsp_data     <= '0;
    end else begin
      rsp_valid    <= snp_valid;
      rsp_has_data <= supply;
      rsp_dirty    <= supply && (line_st == ST_M);
      rsp_data     <= supply ? line_data : '0;
    end
  end
endmodule

// File: rtl/l1_mesi_ctrl.sv
module l1_mesi_ctrl
  import l1_mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   core_req_valid,
  output logic                   core_req_ready,
  input  logic                   core_req_write,
  input  logic [IDX_W+TAG_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0]      core_req_wdata,
  output logic                   core_rsp_valid,
  output logic [DATA_W-1:0]      core_rsp_data,
  output logic                   l2_req_valid,
  input  logic                   l2_req_ready,
  output logic [1:0]             l2_req_type,
  output logic [IDX_W+TAG_W-1:0] l2_req_addr,
  output logic [DATA_W-1:0]      l2_req_data,
  input  logic                   l2_gnt_valid,
  input  logic                   l2_gnt_excl,
  input  logic [DATA_W-1:0]      l2_gnt_data,
  input  logic                   snp_valid,
  input  logic                   snp_type,
  input  logic [IDX_W+TAG_W-1:0] snp_addr,
  output logic                   snp_rsp_valid,
  output logic                   snp_rsp_has_data,
  output logic                   snp_rsp_dirty,
  output logic [DATA_W-1:0]      snp_rsp_data
);
  localparam int ADDR_W = IDX_W + TAG_W;

  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_REQ, F_WAIT} fsm_t;

  fsm_t              fsm_q, fsm_d;
  logic              pend_wr_q, pend_wr_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic [DATA_W-1:0] pend_wdata_q, pend_wdata_d;
  logic [1:0]        pend_type_q, pend_type_d;
  logic              rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  logic [IDX_W-1:0]  rd_idx;
  logic [TAG_W-1:0]  rd_tag, sn_tag;
  line_st_t          rd_st, sn_st;
  logic [DATA_W-1:0] rd_data, sn_data;

  logic              fw_en, fw_data_en;
  logic [TAG_W-1:0]  fw_tag;
  line_st_t          fw_st;
  logic [DATA_W-1:0] fw_data;
  logic              sw_en;
  line_st_t          sw_st;

  logic [TAG_W-1:0]  core_tag;
  logic              accept, hit;

  assign core_req_ready = (fsm_q == F_IDLE) && !snp_valid;
  assign accept         = core_req_valid && core_req_ready;
  assign core_tag       = core_req_addr[ADDR_W-1:IDX_W];
  assign rd_idx         = (fsm_q == F_IDLE) ? core_req_addr[IDX_W-1:0]
                                            : pend_addr_q[IDX_W-1:0];
  assign hit            = (rd_st != ST_I) && (rd_tag == core_tag);

  l1_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_st(rd_st), .rd_data(rd_data),
    .sn_idx(snp_addr[IDX_W-1:0]), .sn_tag(sn_tag), .sn_st(sn_st), .sn_data(sn_data),
    .fw_en(fw_en), .fw_idx(rd_idx), .fw_tag(fw_tag), .fw_st(fw_st),
    .fw_data_en(fw_data_en), .fw_data(fw_data),
    .sw_en(sw_en), .sw_idx(snp_addr[IDX_W-1:0]), .sw_st(sw_st)
  );

  l1_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_type(snp_type), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_tag(sn_tag), .line_st(sn_st), .line_data(sn_data),
    .upd_en(sw_en), .upd_st(sw_st),
    .rsp_valid(snp_rsp_valid), .rsp_has_data(snp_rsp_has_data),
    .rsp_dirty(snp_rsp_dirty), .rsp_data(snp_rsp_data)
  );

  always_comb begin
    fsm_d        = fsm_q;
    pend_wr_d    = pend_wr_q;
    pend_addr_d  = pend_addr_q;
    pend_wdata_d = pend_wdata_q;
    pend_type_d  = pend_type_q;
    rsp_v_d      = 1'b0;
    rsp_data_d   = rsp_data_q;
    fw_en        = 1'b0;
    fw_data_en   = 1'b0;
    fw_tag       = rd_tag;
    fw_st        = rd_st;
    fw_data      = core_req_wdata;
    l2_req_valid = 1'b0;
    l2_req_type  = REQ_GETS;
    l2_req_addr  = pend_addr_q;
    l2_req_data  = '0;
    case (fsm_q)
      F_IDLE: if (accept) begin
        pend_wr_d    = core_req_write;
        pend_addr_d  = core_req_addr;
        pend_wdata_d = core_req_wdata;
        if (hit && !core_req_write) begin
          rsp_v_d    = 1'b1;
          rsp_data_d = rd_data;
        end else if (hit && (rd_st == ST_M || rd_st == ST_E)) begin
          // local write: exclusive copy needs no permission
          fw_en      = 1'b1;
          fw_st      = ST_M;
          fw_data_en = 1'b1;
          rsp_v_d    = 1'b1;
          rsp_data_d = core_req_wdata;
        end else if (hit) begin
          pend_type_d = REQ_GETX;
          fsm_d       = F_REQ;
        end else begin
          pend_type_d = core_req_write ? REQ_GETX : REQ_GETS;
          if (rd_st == ST_M) begin
            fsm_d = F_EVICT;
          end else begin
            // clean victim dropped without a message
            fsm_d = F_REQ;
            fw_en = (rd_st != ST_I);
            fw_st = ST_I;
          end
        end
      end
      F_EVICT: begin
        l2_req_valid = 1'b1;
        l2_req_type  = REQ_PUTX;
        l2_req_addr  = {rd_tag, rd_idx};
        l2_req_data  = rd_data;
        if (l2_req_ready) begin
          fw_en = 1'b1;
          fw_st = ST_I;
          fsm_d = F_REQ;
        end
      end
      F_REQ: begin
        l2_req_valid = 1'b1;
        l2_req_type  = pend_type_q;
        if (l2_req_ready) fsm_d = F_WAIT;
      end
      F_WAIT: if (l2_gnt_valid) begin
        fw_en      = 1'b1;
        fw_tag     = pend_addr_q[ADDR_W-1:IDX_W];
        fw_data_en = 1'b1;
        fw_data    = pend_wr_q ? pend_wdata_q : l2_gnt_data;
        fw_st      = pend_wr_q ? ST_M : (l2_gnt_excl ? ST_E : ST_S);
        rsp_v_d    = 1'b1;
        rsp_data_d = fw_data;
        fsm_d      = F_IDLE;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q        <= F_IDLE;
      pend_wr_q    <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      pend_type_q  <= REQ_GETS;
      rsp_v_q      <= 1'b0;
      rsp_data_q   <= '0;
    end else begin
      fsm_q        <= fsm_d;
      pend_wr_q    <= pend_wr_d;
      pend_addr_q  <= pend_addr_d;
      pend_wdata_q <= pend_wdata_d;
      pend_type_q  <= pend_type_d;
      rsp_v_q      <= rsp_v_d;
      rsp_data_q   <= rsp_data_d;
    end
  end

  assign core_rsp_valid = rsp_v_q;
  assign core_rsp_data  = rsp_data_q;
endmodule

// File: rtl/l1_mesi_ctrl_chk.sv
module l1_mesi_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_ready,
  input logic              core_rsp_valid,
  input logic              l2_req_valid,
  input logic              l2_req_ready,
  input logic [1:0]        l2_req_type,
  input logic [ADDR_W-1:0] l2_req_addr,
  input logic              l2_gnt_valid,
  input logic              snp_valid,
  input logic              snp_rsp_valid,
  input logic              snp_rsp_has_data,
  input logic              snp_rsp_dirty
);
  // R9
  miss_stalls_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_valid |-> !core_req_ready);

  // R10
  snoop_stalls_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !core_req_ready);

  // R10
  snoop_ack_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_rsp_valid);

  // R10
  snoop_ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> !snp_rsp_valid);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_req_valid && !l2_req_ready) |=>
      (l2_req_valid && $stable(l2_req_type) && $stable(l2_req_addr)));

  // R8
  dirty_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rsp_dirty |-> snp_rsp_has_data);

  // R2
  grant_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_gnt_valid |=> core_rsp_valid);
endmodule

bind l1_mesi_ctrl l1_mesi_ctrl_chk #(.ADDR_W(IDX_W + TAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .core_req_ready(core_req_ready), .core_rsp_valid(core_rsp_valid),
  .l2_req_valid(l2_req_valid), .l2_req_ready(l2_req_ready),
  .l2_req_type(l2_req_type), .l2_req_addr(l2_req_addr),
  .l2_gnt_valid(l2_gnt_valid), .snp_valid(snp_valid),
  .snp_rsp_valid(snp_rsp_valid), .snp_rsp_has_data(snp_rsp_has_data),
  .snp_rsp_dirty(snp_rsp_dirty)
);

// File: tb/l1_mesi_ctrl_tb_top.sv
`timescale 1ns/100ps
module l1_mesi_ctrl_tb_top;
  localparam int IDX_W = 2, TAG_W = 4, DATA_W = 16;
  localparam int AW = IDX_W + TAG_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic core_req_valid = 0, core_req_write = 0;
  logic [AW-1:0] core_req_addr = '0;
  logic [DATA_W-1:0] core_req_wdata = '0;
  logic core_req_ready, core_rsp_valid;
  logic [DATA_W-1:0] core_rsp_data;
  logic l2_req_valid, l2_req_ready = 0;
  logic [1:0] l2_req_type;
  logic [AW-1:0] l2_req_addr;
  logic [DATA_W-1:0] l2_req_data;
  logic l2_gnt_valid = 0, l2_gnt_excl = 0;
  logic [DATA_W-1:0] l2_gnt_data = '0;
  logic snp_valid = 0, snp_type = 0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_rsp_valid, snp_rsp_has_data, snp_rsp_dirty;
  logic [DATA_W-1:0] snp_rsp_data;

  l1_mesi_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int n_gets = 0, n_getx = 0, n_putx = 0, n_rsp = 0;
  logic [AW-1:0] putx_addr;
  logic [DATA_W-1:0] putx_data;
  logic shared_mode = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic done = 0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mem_val(input logic [AW-1:0] a);
    return 16'h5A00 + DATA_W'(a);
  endfunction

  // monitor: compare each core response with the head of the scoreboard
  always @(negedge clk) if (rst_n && core_rsp_valid) begin
    logic [DATA_W-1:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
    check(core_rsp_data == e, "R2/R3/R6 rsp data", core_rsp_data, e);
    n_rsp++;
  end

  // L2 model: stall one cycle, check hold and core stall, then grant
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && l2_req_valid) begin
        logic [1:0] t;
        logic [AW-1:0] a;
        t = l2_req_type;
        a = l2_req_addr;
        check(!core_req_ready, "R9 core stalled during miss", core_req_ready, 0);
        @(negedge clk);
        check(l2_req_valid && l2_req_type == t && l2_req_addr == a, "R12 request held",
              {l2_req_type, l2_req_addr}, {t, a});
        l2_req_ready = 1;
        if (t == 2'd2) begin
          n_putx++;
          putx_addr = l2_req_addr;
          putx_data = l2_req_data;
        end
        @(posedge clk); #1;
        l2_req_ready = 0;
        if (t != 2'd2) begin
          if (t == 2'd0) n_gets++; else n_getx++;
          l2_gnt_valid = 1;
          l2_gnt_excl  = (t == 2'd1) ? 1'b1 : !shared_mode;
          l2_gnt_data  = mem_val(a);
          @(posedge clk); #1;
          l2_gnt_valid = 0;
        end
      end
    end
  end

  task automatic core_op(input logic wr, input logic [AW-1:0] a, input logic [DATA_W-1:0] d,
                         input logic [DATA_W-1:0] exp);
    int start;
    start = n_rsp;
    exp_q.push_back(exp);
    @(posedge clk); #1;
    core_req_valid = 1; core_req_write = wr; core_req_addr = a; core_req_wdata = d;
    do @(negedge clk); while (!core_req_ready);
    @(posedge clk); #1;
    core_req_valid = 0;
    while (n_rsp == start) @(negedge clk);
  endtask

  task automatic snoop(input logic ty, input logic [AW-1:0] a, input logic exp_data,
                       input logic exp_dirty, input logic [DATA_W-1:0] exp_val, input string req);
    @(posedge clk); #1;
    snp_valid = 1; snp_type = ty; snp_addr = a;
    @(negedge clk);
    check(!core_req_ready, "R10 snoop blocks core", core_req_ready, 0);
    @(posedge clk); #1;
    snp_valid = 0;
    check(snp_rsp_valid, "R10 snoop ack", snp_rsp_valid, 1);
    check(snp_rsp_has_data == exp_data && snp_rsp_dirty == exp_dirty, req,
          {snp_rsp_has_data, snp_rsp_dirty}, {exp_data, exp_dirty});
    if (exp_data) check(snp_rsp_data == exp_val, req, snp_rsp_data, exp_val);
  endtask

  localparam logic [AW-1:0] A = 6'h04, B = 6'h08, C = 6'h0C, D = 6'h05, D2 = 6'h09;

  initial begin
    int g, x, p;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    check(core_req_ready && !l2_req_valid && !core_rsp_valid && !snp_rsp_valid,
          "R1 reset idle", {core_req_ready, l2_req_valid, core_rsp_valid, snp_rsp_valid}, 4'b1000);

    // R2 exclusive fill; R1 first load misses
    core_op(0, A, 0, mem_val(A));
    check(n_gets == 1, "R1/R2 GETS issued", n_gets, 1);
    // R3 store on E stays local
    g = n_gets; x = n_getx;
    core_op(1, A, 16'h1111, 16'h1111);
    check(n_gets == g && n_getx == x, "R3 no request on E store", n_gets + n_getx, g + x);
    core_op(0, A, 0, 16'h1111);
    // R5 dirty victim written back, shared fill
    shared_mode = 1;
    core_op(0, B, 0, mem_val(B));
    check(n_putx == 1 && putx_addr == A && putx_data == 16'h1111, "R5 PUTX of victim",
          {putx_addr, putx_data}, {A, 16'h1111});
    // R6 store on S upgrades
    x = n_getx;
    core_op(1, B, 16'h2222, 16'h2222);
    check(n_getx == x + 1, "R6 GETX on S store", n_getx, x + 1);
    core_op(0, B, 0, 16'h2222);
    // R4 silent drops of E then S
    shared_mode = 0;
    p = n_putx;
    core_op(0, D, 0, mem_val(D));
    core_op(0, D2, 0, mem_val(D2));
    check(n_putx == p, "R4 E victim silent", n_putx, p);
    shared_mode = 1;
    core_op(0, D, 0, mem_val(D));
    core_op(0, D2, 0, mem_val(D2));
    check(n_putx == p, "R4 S victim silent", n_putx, p);
    // R6 store miss installs M
    x = n_getx;
    core_op(1, 6'h06, 16'h6666, 16'h6666);
    check(n_getx == x + 1, "R6 GETX on store miss", n_getx, x + 1);
    core_op(0, 6'h06, 0, 16'h6666);

    // R7 invalidate on M
    snoop(0, B, 1, 1, 16'h2222, "R7 INV on M returns dirty data");
    g = n_gets;
    shared_mode = 0;
    core_op(0, B, 0, mem_val(B));
    check(n_gets == g + 1, "R7 line gone after INV", n_gets, g + 1);
    // R8 forward on E
    snoop(1, B, 1, 0, mem_val(B), "R8 FWD on E clean data");
    x = n_getx;
    core_op(1, B, 16'h3333, 16'h3333);
    check(n_getx == x + 1, "R8 line is S after FWD", n_getx, x + 1);
    // R8 forward on M
    snoop(1, B, 1, 1, 16'h3333, "R8 FWD on M dirty data");
    // R11 tag mismatch and S-line invalidate-free forward
    snoop(0, C, 0, 0, 0, "R11 mismatch no data");
    snoop(1, B, 0, 0, 0, "R11 FWD on S no data");
    g = n_gets;
    core_op(0, B, 0, 16'h3333);
    check(n_gets == g, "R11 line kept after mismatch", n_gets, g);
    // R7 invalidate on S: no data, line gone
    snoop(0, B, 0, 0, 0, "R7 INV on S no data");
    core_op(0, B, 0, mem_val(B));
    check(n_gets == g + 1, "R7 S line invalidated", n_gets, g + 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule